// File: doc/BRIEF.md
# Receive Line Status Tracker

This block stands between a serial receiver and the processor that drains it. Every character the receiver completes arrives with two error tags, a bad-parity tag and a missing-stop-bit tag. The block buffers the character and keeps an 8-bit status word that the processor reads through a strobe. A second strobe pops the oldest character. A third strobe writes to the status word and has no effect. An interrupt line is raised while any error bit in the status word is set.

Two buffering modes are selected by `fifo_mode`. With the input low, a single holding register is used. With it high, a queue of `DEPTH` entries is used. In both modes the error tags travel with their own character. They reach the status word only when that character becomes the oldest one held, so an error never shows up early against a clean character ahead of it. Once shown, an error bit stays set until the processor reads the status word, even if the character has already been popped.

Top module: `rx_line_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 in the cycle after a character is stored. It returns to 0 once every held character has been popped. Bits 7:4 of the status word always read 0.
- R2: A data-read strobe pops the oldest character. `data_out` always shows the oldest held character, so characters leave in arrival order.
- R3: In holding-register mode, a character that arrives while the register is full and no pop happens in the same cycle replaces the held character. It also sets status bit 1 (overrun).
- R4: In queue mode, a character that arrives while all `DEPTH` entries are full and no pop happens in the same cycle is discarded. It sets status bit 1, and the queue contents are left unchanged.
- R5: A character that arrives in the same cycle as a pop of a full store is accepted without an overrun.
- R6: Status bit 1 is visible in the cycle right after the arrival that caused the overrun.
- R7: Status bit 2 (parity error) and status bit 3 (framing error) show a character's tags only from the cycle in which that character is the oldest held one. Once shown, they stay set.
- R8: A status read clears bits 1 to 3 and leaves bit 0 unchanged. An error event in the same cycle as the read wins, and its bit stays set.
- R9: `line_irq` is 1 exactly when at least one of status bits 1 to 3 is 1.
- R10: A status-write strobe changes neither the status word nor `line_irq`.
- R11: A change of `fifo_mode` empties the store on the next clock edge. Bits 1 to 3 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 selects queue mode, 0 selects holding-register mode |
| char_done | input | 1 | Strobe for a completed received character |
| char_data | input | DATA_W | Completed character |
| char_par_err | input | 1 | Parity error tag of the completed character |
| char_frm_err | input | 1 | Stop-bit error tag of the completed character |
| rd_data | input | 1 | Data read strobe; pops the oldest character |
| rd_status | input | 1 | Status read strobe; clears the error bits |
| wr_status | input | 1 | Status write strobe; has no effect |
| data_out | output | DATA_W | Oldest held character |
| status_out | output | 8 | Status word: ready, overrun, parity, framing in bits 0 to 3 |
| line_irq | output | 1 | Receiver line status interrupt |

## Verification
A vector table drives the queue with a clean character followed by characters carrying a parity tag, a framing tag and both tags. It mixes pops and status reads between them. This separates errors shown at the head from errors shown on arrival, and shows that a status read clears the errors while leaving ready alone. Directed runs fill the store completely and then add one more character, both with and without a pop in the same cycle. This separates a discarded character from a replaced one and from an accepted one, and confirms that the pop order is unchanged. Further runs cover overwrite in holding-register mode, a status read that meets a new overrun in the same cycle, status writes, and the flush on a mode change.

// File: rtl/rls_pkg.sv
package rls_pkg;
   // bit positions inside the status word
   localparam int ST_READY = 0;
   localparam int ST_OVR   = 1;
   localparam int ST_PAR   = 2;
   localparam int ST_FRM   = 3;
   localparam int ST_W     = 8;
   localparam int TAG_W    = 2;

   typedef struct packed {
      logic par;
      logic frm;
   } rls_tags_t;
endpackage

// File: rtl/rls_store.sv
module rls_store
   import rls_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int EW    = DATA_W + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic              pop,
   input  logic              ovw,
   input  logic [DATA_W-1:0] in_data,
   input  rls_tags_t         in_tags,
   output logic [DATA_W-1:0] head_data,
   output rls_tags_t         head_tags,
   output logic [CW-1:0]     count
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("rls_store: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rls_store: DATA_W must be at least 1");
   end

   logic [EW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (!flush) begin
         if (push)     mem[wr_ptr] <= {in_tags, in_data};
         else if (ovw) mem[rd_ptr] <= {in_tags, in_data};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign {head_tags, head_data} = mem[rd_ptr];

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !flush) |-> (count < CW'(DEPTH)));

   // R2
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
endmodule

// File: rtl/rls_admit.sv
module rls_admit #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          fifo_mode,
   input  logic          flush,
   input  logic          char_done,
   input  logic          rd_data,
   input  logic [CW-1:0] count,
   output logic          push,
   output logic          pop,
   output logic          ovw,
   output logic          ovr_evt,
   output logic          reveal
);
   logic [CW-1:0] limit;
   logic          room, arrive, is0, is1;

   always_comb begin
      limit   = fifo_mode ? CW'(DEPTH) : CW'(1);
      is0     = (count == '0);
      is1     = (count == CW'(1));
      arrive  = char_done && !flush;
      pop     = rd_data && !is0 && !flush;
      room    = (count < limit) || pop;
      push    = arrive && room;
      ovw     = arrive && !room && !fifo_mode;
      ovr_evt = arrive && !room;
      // a different character becomes the oldest one held
      reveal  = ovw || (pop && !is1) || (push && (is0 || (pop && is1)));
   end
endmodule

// File: rtl/rls_flags.sv
module rls_flags
   import rls_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      reveal,
   input  logic      ovr_evt,
   input  logic      rd_status,
   input  logic      has_data,
   input  rls_tags_t head_tags,
   output logic      ovr,
   output logic      par,
   output logic      frm
);
   logic ovr_q, par_q, frm_q, pend_q;
   logic par_vis, frm_vis;

   assign par_vis = par_q || (pend_q && has_data && head_tags.par);
   assign frm_vis = frm_q || (pend_q && has_data && head_tags.frm);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_q  <= 1'b0;
         par_q  <= 1'b0;
         frm_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         ovr_q  <= ovr_evt || (ovr_q && !rd_status);
         par_q  <= par_vis && !rd_status;
         frm_q  <= frm_vis && !rd_status;
         pend_q <= reveal;
      end
   end

   assign ovr = ovr_q;
   assign par = par_vis;
   assign frm = frm_vis;

   // R6
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> ovr);

   // R8
   ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !ovr_evt) |=> !ovr);

   // R8
   par_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !reveal) |=> !par);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
   import rls_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode,
   input  logic              char_done,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_par_err,
   input  logic              char_frm_err,
   input  logic              rd_data,
   input  logic              rd_status,
   input  logic              wr_status,
   output logic [DATA_W-1:0] data_out,
   output logic [ST_W-1:0]   status_out,
   output logic              line_irq
);
   localparam int CW = $clog2(DEPTH + 1);

   logic          mode_q, flush;
   logic          push, pop, ovw, ovr_evt, reveal;
   logic [CW-1:0] count;
   rls_tags_t     in_tags, head_tags;
   logic          ovr, par, frm, ready;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= fifo_mode;
   end
   assign flush = (fifo_mode != mode_q);

   assign in_tags.par = char_par_err;
   assign in_tags.frm = char_frm_err;

   rls_admit #(.DEPTH(DEPTH)) admit_i (
      .fifo_mode (fifo_mode),
      .flush     (flush),
      .char_done (char_done),
      .rd_data   (rd_data),
      .count     (count),
      .push      (push),
      .pop       (pop),
      .ovw       (ovw),
      .ovr_evt   (ovr_evt),
      .reveal    (reveal)
   );

   rls_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (push),
      .pop       (pop),
      .ovw       (ovw),
      .in_data   (char_data),
      .in_tags   (in_tags),
      .head_data (data_out),
      .head_tags (head_tags),
      .count     (count)
   );

   assign ready = (count != '0);

   rls_flags flags_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reveal    (reveal),
      .ovr_evt   (ovr_evt),
      .rd_status (rd_status),
      .has_data  (ready),
      .head_tags (head_tags),
      .ovr       (ovr),
      .par       (par),
      .frm       (frm)
   );

   always_comb begin
      status_out           = '0;
      status_out[ST_READY] = ready;
      status_out[ST_OVR]   = ovr;
      status_out[ST_PAR]   = par;
      status_out[ST_FRM]   = frm;
   end
   assign line_irq = ovr || par || frm;

   // R1
   ready_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> status_out[ST_READY]);

   // R10
   wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && !rd_status && !char_done && !rd_data && !flush)
      |=> ($stable(status_out) && $stable(line_irq)));

   // R3
   hold_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_mode && !flush && count <= CW'(1)) |=> (count <= CW'(1) || fifo_mode));
endmodule

// File: tb/rx_line_status_tb_top.sv
module rx_line_status_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_mode = 1'b1;
   logic       char_done = 1'b0;
   logic [7:0] char_data = '0;
   logic       char_par_err = 1'b0;
   logic       char_frm_err = 1'b0;
   logic       rd_data = 1'b0;
   logic       rd_status = 1'b0;
   logic       wr_status = 1'b0;
   logic [7:0] data_out;
   logic [7:0] status_out;
   logic       line_irq;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rx_line_status #(.DEPTH(16), .DATA_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
      .char_done(char_done), .char_data(char_data),
      .char_par_err(char_par_err), .char_frm_err(char_frm_err),
      .rd_data(rd_data), .rd_status(rd_status), .wr_status(wr_status),
      .data_out(data_out), .status_out(status_out), .line_irq(line_irq)
   );

   // fields: cd, data, par, frm, rdd, rds, expected data_out, expected status[3:0]
   localparam logic [24:0] VEC [12] = '{
      {1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 4'b0001},
      {1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 4'b0001},
      {1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 4'b0001},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 4'b0101},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 4'b0001},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h7E, 4'b1001},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 4'b0000},
      {1'b1, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 4'b1101},
      {1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22, 4'b1101},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h22, 4'b0001},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'b0000},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 4'b0000}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step(input logic cd, input logic [7:0] d, input logic pe, input logic fe,
                       input logic rdd, input logic rds, input logic wr);
      char_done = cd; char_data = d; char_par_err = pe; char_frm_err = fe;
      rd_data = rdd; rd_status = rds; wr_status = wr;
      @(negedge clk);
      char_done = 1'b0; char_par_err = 1'b0; char_frm_err = 1'b0;
      rd_data = 1'b0; rd_status = 1'b0; wr_status = 1'b0;
   endtask

   task automatic push(input logic [7:0] d);
      step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R1 reset status", 32'(status_out), 32'h00);
      check("R9 reset irq", 32'(line_irq), 32'h0);

      // table walk in queue mode: R1 R2 R7 R8 R9
      for (int v = 0; v < 12; v++) begin
         step(VEC[v][24], VEC[v][23:16], VEC[v][15], VEC[v][14], VEC[v][13], VEC[v][12], 1'b0);
         check("R7/R8 table status", 32'(status_out), 32'(VEC[v][3:0]));
         check("R9 table irq", 32'(line_irq), 32'(|VEC[v][3:1]));
         if (VEC[v][0]) check("R2 table data", 32'(data_out), 32'(VEC[v][11:4]));
      end

      // R4 / R6: fill, then one more is dropped
      for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
      check("R4 full no overrun", 32'(status_out), 32'h01);
      push(8'hEE);
      check("R6 overrun next cycle", 32'(status_out), 32'h03);
      check("R9 irq on overrun", 32'(line_irq), 32'h1);
      for (int i = 0; i < 16; i++) begin
         check("R4 contents kept in order", 32'(data_out), 32'(8'(i * 3 + 1)));
         step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      end
      check("R1 ready clears when drained", 32'(status_out), 32'h02);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R8 status read clears overrun", 32'(status_out), 32'h00);

      // R5: arrival with pop at full
      for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
      step(1'b1, 8'h99, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R5 no overrun on pop at full", 32'(status_out), 32'h01);
      for (int i = 1; i < 16; i++) begin
         check("R5 order after pop", 32'(data_out), 32'(8'(8'h40 + i)));
         step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      end
      check("R5 accepted char last", 32'(data_out), 32'h99);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R1 empty after R5", 32'(status_out), 32'h00);

      // R10: status writes do nothing
      step(1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R7 framing on arrival at head", 32'(status_out), 32'h09);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      check("R10 write keeps error bits", 32'(status_out), 32'h09);
      check("R10 write keeps irq", 32'(line_irq), 32'h1);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R8 read keeps ready", 32'(status_out), 32'h01);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      check("R10 write keeps clean status", 32'(status_out), 32'h01);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

      // R3: holding-register mode overwrite
      fifo_mode = 1'b0;
      @(negedge clk);
      push(8'h41);
      check("R3 first held", 32'(status_out), 32'h01);
      push(8'h42);
      check("R3 overwrite sets overrun", 32'(status_out), 32'h03);
      check("R3 newest kept", 32'(data_out), 32'h42);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R3 single entry held", 32'(status_out), 32'h02);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R8 clear in hold mode", 32'(status_out), 32'h00);

      // R8: event in the same cycle as a status read wins
      push(8'h50);
      push(8'h51);
      step(1'b1, 8'h52, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R8 overrun wins over read", 32'(status_out), 32'h03);
      check("R3 overwrite with read", 32'(data_out), 32'h52);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R8 read leaves ready", 32'(status_out), 32'h01);

      // R11: mode change flushes, keeps error bits
      push(8'h53);
      check("R11 setup overrun", 32'(status_out), 32'h03);
      fifo_mode = 1'b1;
      @(negedge clk);
      check("R11 flush on mode change", 32'(status_out), 32'h02);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R11 clean after read", 32'(status_out), 32'h00);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule